// File: doc/BRIEF.md
# Interleaved MSI Vector Interrupt Aggregator

This block receives message-signalled interrupts as vector numbers and routes them to eight level interrupt lines for the host. There are thirty-two vectors. They are interleaved across the lines. A vector's group is its number modulo eight, and its bit inside the group is the number divided by eight. Each group therefore holds four status bits, and those bits stand for vectors that are eight apart.

Software uses a 32-bit register port with one write channel and one read channel. Each group has three registers: a status register that is cleared by writing ones, an enable-set register and an enable-clear register. One shared end-of-interrupt register serves all groups. A group's line is high while at least one of its status bits is set and enabled. After an end-of-interrupt write, the line drops for one cycle, so an edge-sensitive host controller sees work that is still pending.

Top module: `msi_irq_agg`

## Requirements
- R1: After reset, every status bit, every enable bit, every line of `irq_o` and `reg_rd_data` are zero.
- R2: An MSI write with vector v (0..31) on `msi_wr_data` sets bit v>>3 of group v%8. Software reads group g's status at offset 0x104+16*g, in bits 3:0.
- R3: An MSI write whose 32-bit value is 32 or more changes no status bit.
- R4: A register write to 0x108+16*g sets each enable bit of group g whose data bit (3:0) is one and leaves the others alone. The enable mask reads back in bits 3:0 at both 0x108+16*g and 0x10C+16*g.
- R5: A register write to 0x10C+16*g clears each enable bit of group g whose data bit is one. Zero bits have no effect.
- R6: `irq_o[g]` is registered. After the clock edge that makes the change, it is high exactly when group g has a status bit that is both set and enabled. A disabled pending bit does not raise the line.
- R7: A register write to 0x104+16*g clears each status bit of group g whose data bit is one. Zero bits leave status unchanged.
- R8: If an MSI sets a status bit in the same cycle that a register write clears that bit, the bit ends up set.
- R9: A write of value g+4 to offset 0x050 drives `irq_o[g]` low for the cycle after the edge. The line then returns to its pending state. Other lines are not affected, and values outside 4..11 have no effect.
- R10: A read returns its data on `reg_rd_data` one cycle after `reg_rd_en`. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_wr_en | input | 1 | MSI target register write strobe |
| msi_wr_data | input | 32 | Vector number written by the MSI |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 12 | Register read byte offset |
| reg_rd_data | output | 32 | Registered read data |
| irq_o | output | 8 | Level interrupt line per group |

## Verification
The assertions assume that at most one register write arrives per cycle. Under that assumption, an enable-set and an enable-clear of the same group never coincide, and the end-of-interrupt strobes are one-hot. They also assume that reset is held through the first edge. The stimulus respects both: each task issues a single register access per cycle, starts only after reset has been released, and produces the one deliberate MSI-versus-clear overlap by driving the separate MSI port alongside a register write.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int OFS_EOI      = 'h050;
  localparam int OFS_GRP_BASE = 'h100;
  localparam int SUB_STATUS   = 'h4;
  localparam int SUB_EN_SET   = 'h8;
  localparam int SUB_EN_CLR   = 'hC;
  localparam int EOI_BIAS     = 4;
endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int NUM_GROUPS     = 8,
  parameter int BITS_PER_GROUP = 4,
  parameter int DATA_W         = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               msi_wr_en,
  input  logic [DATA_W-1:0]                  msi_wr_data,
  output logic [NUM_GROUPS*BITS_PER_GROUP-1:0] set_o
);
  localparam int NUM_VEC = NUM_GROUPS * BITS_PER_GROUP;

  // flat index g*B+b holds vector g + b*G
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < BITS_PER_GROUP; b++) begin : g_bit
      assign set_o[g*BITS_PER_GROUP+b] =
        msi_wr_en && (msi_wr_data == DATA_W'(g + b*NUM_GROUPS));
    end
  end

  // R3
  oob_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_wr_en && (msi_wr_data >= DATA_W'(NUM_VEC))) |-> (set_o == '0));

  // R2
  single_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_o));
endmodule

// File: rtl/msi_reg_if.sv
module msi_reg_if
  import msi_agg_pkg::*;
#(
  parameter int NUM_GROUPS     = 8,
  parameter int BITS_PER_GROUP = 4,
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic                                 rd_en,
  input  logic [ADDR_W-1:0]                    rd_addr,
  input  logic [NUM_GROUPS*BITS_PER_GROUP-1:0] status_i,
  input  logic [NUM_GROUPS*BITS_PER_GROUP-1:0] enable_i,
  output logic [NUM_GROUPS*BITS_PER_GROUP-1:0] w1c_o,
  output logic [NUM_GROUPS*BITS_PER_GROUP-1:0] en_set_o,
  output logic [NUM_GROUPS*BITS_PER_GROUP-1:0] en_clr_o,
  output logic [NUM_GROUPS-1:0]                eoi_o,
  output logic [DATA_W-1:0]                    rd_data_o
);
  localparam int GW    = $clog2(NUM_GROUPS);
  localparam int TAG_W = ADDR_W - GW - 4;
  localparam logic [TAG_W-1:0] GRP_TAG = TAG_W'(OFS_GRP_BASE >> (GW + 4));
  localparam int B = BITS_PER_GROUP;

  logic          wr_grp_hit, rd_grp_hit;
  logic [GW-1:0] wr_idx, rd_idx;
  logic [3:0]    wr_sub, rd_sub;

  assign wr_grp_hit = wr_en && (wr_addr[ADDR_W-1:GW+4] == GRP_TAG);
  assign wr_idx     = wr_addr[GW+3:4];
  assign wr_sub     = wr_addr[3:0];
  assign rd_grp_hit = rd_addr[ADDR_W-1:GW+4] == GRP_TAG;
  assign rd_idx     = rd_addr[GW+3:4];
  assign rd_sub     = rd_addr[3:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_wdec
    logic sel;
    assign sel = wr_grp_hit && (wr_idx == GW'(g));
    assign w1c_o[g*B +: B]    = (sel && wr_sub == 4'(SUB_STATUS)) ? wr_data[B-1:0] : '0;
    assign en_set_o[g*B +: B] = (sel && wr_sub == 4'(SUB_EN_SET)) ? wr_data[B-1:0] : '0;
    assign en_clr_o[g*B +: B] = (sel && wr_sub == 4'(SUB_EN_CLR)) ? wr_data[B-1:0] : '0;
    assign eoi_o[g] = wr_en && (wr_addr == ADDR_W'(OFS_EOI)) &&
                      (wr_data == DATA_W'(g + EOI_BIAS));
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_grp_hit) begin
      if (rd_sub == 4'(SUB_STATUS))
        rd_next[B-1:0] = status_i[int'(rd_idx)*B +: B];
      else if (rd_sub == 4'(SUB_EN_SET) || rd_sub == 4'(SUB_EN_CLR))
        rd_next[B-1:0] = enable_i[int'(rd_idx)*B +: B];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_next;
  end

  // R9
  eoi_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eoi_o));

  // R5
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_set_o & en_clr_o) == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data_o));
endmodule

// File: rtl/msi_group.sv
module msi_group #(
  parameter int BITS_PER_GROUP = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BITS_PER_GROUP-1:0] set_i,
  input  logic [BITS_PER_GROUP-1:0] w1c_i,
  input  logic [BITS_PER_GROUP-1:0] en_set_i,
  input  logic [BITS_PER_GROUP-1:0] en_clr_i,
  input  logic                      eoi_i,
  output logic [BITS_PER_GROUP-1:0] status_o,
  output logic [BITS_PER_GROUP-1:0] enable_o,
  output logic                      irq_o
);
  logic [BITS_PER_GROUP-1:0] status_d, enable_d;

  // a new MSI wins over a clear of the same bit
  assign status_d = (status_o & ~w1c_i) | set_i;
  assign enable_d = (enable_o | en_set_i) & ~en_clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= status_d;
      enable_o <= enable_d;
      irq_o    <= (|(status_d & enable_d)) && !eoi_i;
    end
  end

  // R8
  set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|(w1c_i & ~set_i)) |=> ((status_o & $past(w1c_i & ~set_i)) == '0));

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|(en_set_i & ~en_clr_i)) |=>
      ((enable_o & $past(en_set_i & ~en_clr_i)) == $past(en_set_i & ~en_clr_i)));

  // R6
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|(status_o & enable_o)));

  // R9
  eoi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_i |=> !irq_o);
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg #(
  parameter int NUM_GROUPS     = 8,
  parameter int BITS_PER_GROUP = 4,
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  msi_wr_en,
  input  logic [DATA_W-1:0]     msi_wr_data,
  input  logic                  reg_wr_en,
  input  logic [ADDR_W-1:0]     reg_wr_addr,
  input  logic [DATA_W-1:0]     reg_wr_data,
  input  logic                  reg_rd_en,
  input  logic [ADDR_W-1:0]     reg_rd_addr,
  output logic [DATA_W-1:0]     reg_rd_data,
  output logic [NUM_GROUPS-1:0] irq_o
);
  localparam int NV = NUM_GROUPS * BITS_PER_GROUP;
  localparam int B  = BITS_PER_GROUP;

  logic [NV-1:0]         msi_set, w1c, en_set, en_clr, status, enable;
  logic [NUM_GROUPS-1:0] eoi;

  msi_vec_decode #(
    .NUM_GROUPS(NUM_GROUPS), .BITS_PER_GROUP(BITS_PER_GROUP), .DATA_W(DATA_W)
  ) u_decode (
    .clk(clk), .rst(rst), .msi_wr_en(msi_wr_en), .msi_wr_data(msi_wr_data),
    .set_o(msi_set)
  );

  msi_reg_if #(
    .NUM_GROUPS(NUM_GROUPS), .BITS_PER_GROUP(BITS_PER_GROUP),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr),
    .status_i(status), .enable_i(enable),
    .w1c_o(w1c), .en_set_o(en_set), .en_clr_o(en_clr), .eoi_o(eoi),
    .rd_data_o(reg_rd_data)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    msi_group #(.BITS_PER_GROUP(BITS_PER_GROUP)) u_group (
      .clk(clk), .rst(rst),
      .set_i(msi_set[g*B +: B]), .w1c_i(w1c[g*B +: B]),
      .en_set_i(en_set[g*B +: B]), .en_clr_i(en_clr[g*B +: B]),
      .eoi_i(eoi[g]),
      .status_o(status[g*B +: B]), .enable_o(enable[g*B +: B]),
      .irq_o(irq_o[g])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && reg_rd_data == '0));
endmodule

// File: tb/msi_irq_agg_bench.sv
module msi_irq_agg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msi_wr_en = 1'b0;
  logic [31:0] msi_wr_data = '0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_irq_agg u_msi_irq_agg (
    .clk(clk), .rst(rst), .msi_wr_en(msi_wr_en), .msi_wr_data(msi_wr_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .irq_o(irq_o)
  );

  function automatic logic [11:0] st_ofs(int g);  return 12'(32'h104 + 16*g); endfunction
  function automatic logic [11:0] set_ofs(int g); return 12'(32'h108 + 16*g); endfunction
  function automatic logic [11:0] clr_ofs(int g); return 12'(32'h10C + 16*g); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  task automatic msi(logic [31:0] v);
    @(negedge clk);
    msi_wr_en = 1'b1; msi_wr_data = v;
    @(negedge clk);
    msi_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 rd_data", reg_rd_data, 32'h0);
    for (int g = 0; g < 8; g++) begin
      reg_rd(st_ofs(g), d);  check("R1 status", d, 32'h0);
      reg_rd(set_ofs(g), d); check("R1 enable", d, 32'h0);
    end
  endtask

  task automatic t_capture();
    logic [31:0] d;
    msi(13); msi(0); msi(31);
    reg_rd(st_ofs(5), d); check("R2 vec13", d, 32'h2);
    reg_rd(st_ofs(0), d); check("R2 vec0", d, 32'h1);
    reg_rd(st_ofs(7), d); check("R2 vec31", d, 32'h8);
    check("R6 disabled no irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    msi(32); msi(40); msi(32'h100); msi(32'hFFFF_FFFF);
    reg_rd(st_ofs(0), d); check("R3 g0", d, 32'h1);
    reg_rd(st_ofs(1), d); check("R3 g1", d, 32'h0);
    reg_rd(st_ofs(7), d); check("R3 g7", d, 32'h8);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    reg_wr(set_ofs(5), 32'h2);
    check("R6 enable raises", 32'(irq_o), 32'h20);
    reg_rd(set_ofs(5), d); check("R4 readback set", d, 32'h2);
    reg_rd(clr_ofs(5), d); check("R4 readback clr", d, 32'h2);
    reg_wr(set_ofs(5), 32'h0);
    reg_rd(set_ofs(5), d); check("R4 zero no effect", d, 32'h2);
    reg_wr(clr_ofs(5), 32'h0);
    reg_rd(set_ofs(5), d); check("R5 zero no effect", d, 32'h2);
    check("R5 zero keeps irq", 32'(irq_o), 32'h20);
    reg_wr(clr_ofs(5), 32'h2);
    check("R5 clear drops irq", 32'(irq_o), 32'h0);
    reg_rd(set_ofs(5), d); check("R5 cleared", d, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    msi(5);
    reg_wr(set_ofs(5), 32'h3);
    reg_rd(st_ofs(5), d); check("R2 vec5", d, 32'h3);
    reg_wr(st_ofs(5), 32'h0);
    reg_rd(st_ofs(5), d); check("R7 zero keeps", d, 32'h3);
    reg_wr(st_ofs(5), 32'h1);
    reg_rd(st_ofs(5), d); check("R7 w1c", d, 32'h2);
    check("R6 still pending", 32'(irq_o), 32'h20);
  endtask

  task automatic t_eoi();
    reg_wr(set_ofs(0), 32'h1);
    check("R6 g0 raised", 32'(irq_o), 32'h21);
    reg_wr(12'h050, 32'd9);
    check("R9 pulse low", 32'(irq_o), 32'h01);
    @(negedge clk);
    check("R9 rearmed", 32'(irq_o), 32'h21);
    reg_wr(12'h050, 32'd3);
    check("R9 bad code", 32'(irq_o), 32'h21);
    @(negedge clk);
    check("R9 bad code later", 32'(irq_o), 32'h21);
    reg_wr(st_ofs(5), 32'h2);
    check("R7 last bit cleared", 32'(irq_o), 32'h01);
    reg_wr(12'h050, 32'd9);
    @(negedge clk);
    check("R9 no pending stays low", 32'(irq_o), 32'h01);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    msi_wr_en = 1'b1; msi_wr_data = 32'd6;
    reg_wr_en = 1'b1; reg_wr_addr = st_ofs(6); reg_wr_data = 32'h1;
    @(negedge clk);
    msi_wr_en = 1'b0; reg_wr_en = 1'b0;
    reg_rd(st_ofs(6), d); check("R8 set wins", d, 32'h1);
  endtask

  task automatic t_read();
    logic [31:0] d;
    reg_rd(12'h100, d); check("R10 unmapped 0x100", d, 32'h0);
    reg_rd(12'h050, d); check("R10 unmapped eoi", d, 32'h0);
    reg_rd(12'h800, d); check("R10 unmapped high", d, 32'h0);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = st_ofs(7);
    @(negedge clk);
    reg_rd_en = 1'b0;
    check("R10 one cycle latency", reg_rd_data, 32'h8);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    for (int v = 0; v < 32; v++) msi(v);
    for (int g = 0; g < 8; g++) begin
      reg_rd(st_ofs(g), d); check("R2 sweep", d, 32'hF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_capture();
    t_oob();
    t_enable();
    t_w1c();
    t_eoi();
    t_collide();
    t_read();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %h expected %h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule